// File: doc/BRIEF.md
# Setpoint Transition Request Controller

The block takes a CPU's requests to move the system to another operating setpoint and screens each one against a permission mask before it forwards it. Sixteen setpoints exist, each named by a 4-bit number. Requests come from three sources: a software run request in the control word, a request armed for the next sleep sequence, and a request armed for the next wakeup sequence. The last two fire only on a start pulse from the CPU mode sequencer. The mask is picked by the CPU's present mode (RUN, WAIT, STOP or SUSPEND). An allowed request drives a request/ack handshake toward the system power controller. A refused request sets a per-source interrupt flag and goes no further.

Software reaches the block through a word-wide register port: writes take effect at the clock edge and reads are combinational. A status word gives the current, previous and last requested setpoint. Once the system acknowledges a transition, the current setpoint moves to the target and the old current setpoint becomes the previous one.

Top module: `sp_request_ctrl`

## Requirements
- R1: After reset the control word, interrupt word and status word read 0, all four permission masks read 0xFFFF, and sys_req and irq are low.
- R2: Register index 0 is the control word: run-enable bit 0, run setpoint bits 4:1, sleep-enable bit 5, sleep setpoint bits 9:6, wakeup-enable bit 10, wakeup setpoint bits 14:11, wakeup select bit 15. Bits 31:16 read as 0. Indices 3, 4, 5 and 6 hold the masks for CPU modes 0 (RUN), 1 (WAIT), 2 (STOP) and 3 (SUSPEND), in bits 15:0.
- R3: With the block idle, a set run-enable bit whose setpoint is allowed raises sys_req with sys_sp equal to that setpoint in the cycle after the write. The run-enable bit reads 1 until the acknowledge.
- R4: On a cycle with sys_req and sys_ack both high, sys_req falls, the current setpoint takes sys_sp, the previous setpoint takes the old current value, and a run-sourced request clears the run-enable bit.
- R5: While sys_req is high and sys_ack is low, sys_req and sys_sp hold their values.
- R6: A request is allowed only if bit n of the mask selected by cpu_mode is 1, where n is the requested setpoint. A refused request never raises sys_req and leaves the current setpoint unchanged. It updates the target field. A refused run request clears the run-enable bit.
- R7: A sleep_start pulse, with the sleep-enable bit set and the block idle, requests the sleep setpoint and clears the sleep-enable bit. With the sleep-enable bit clear the pulse has no effect.
- R8: A wakeup_start pulse, with the wakeup-enable bit set and the block idle, clears the wakeup-enable bit and requests the wakeup setpoint field when wakeup select is 1, or the previous setpoint when it is 0.
- R9: When several sources are ready in the same idle cycle, wakeup wins over sleep and sleep wins over run. A losing run request stays pending and is issued after the winner is acknowledged.
- R10: A sleep_start or wakeup_start pulse that arrives while sys_req is high has no effect, and its enable bit stays set.
- R11: Register index 1 holds the interrupt enables for the sleep, wakeup and software sources in bits 0, 1 and 2, and their refusal flags in bits 16, 17 and 18. A refusal sets its flag. Writing 1 to a flag bit clears it, and writing 0 leaves it. irq is high when any flag is set together with its enable.
- R12: Register index 2 is the status word: current setpoint bits 3:0, previous bits 7:4, target bits 11:8, and 0 above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| cpu_mode | input | 2 | Present CPU mode: 0 RUN, 1 WAIT, 2 STOP, 3 SUSPEND |
| sleep_start | input | 1 | One-cycle pulse at the start of a sleep sequence |
| wakeup_start | input | 1 | One-cycle pulse at the start of a wakeup sequence |
| sys_req | output | 1 | Setpoint transition request toward the system |
| sys_sp | output | 4 | Requested setpoint, valid while sys_req is high |
| sys_ack | input | 1 | Acknowledge from the system power controller |
| irq | output | 1 | Refused-request interrupt |

## Verification
A pending software run request and an armed sleep request can reach the issue logic in the same idle cycle. The bench provokes this by writing a control word that sets both the run and the sleep fields, then pulsing sleep_start in the very next cycle, before the run request can be issued alone. The bench judges the result at the ports. The sleep setpoint must appear on sys_sp, the run-enable bit must still read 1 while the sleep-enable bit reads 0, and the run setpoint must be issued in the cycle after the sleep request is acknowledged. A second collision, a sleep pulse during an outstanding run request, must leave sys_sp and the armed enable bit untouched.

// File: rtl/sptr_pkg.sv
package sptr_pkg;
  localparam int SP_W      = 4;
  localparam int NUM_SP    = 1 << SP_W;
  localparam int NUM_MODES = 4;
  localparam int NUM_SRC   = 3;
  localparam int DATA_W    = 32;

  localparam int IDX_CTRL  = 0;
  localparam int IDX_INT   = 1;
  localparam int IDX_STAT  = 2;
  localparam int IDX_MAP0  = 3;

  localparam int INT_FLAG_LSB = 16;

  // Source index also selects the enable/flag bit position.
  typedef enum logic [1:0] {
    SRC_SLEEP = 2'd0,
    SRC_WAKE  = 2'd1,
    SRC_RUN   = 2'd2
  } src_e;

  typedef struct packed {
    logic            wake_sel;
    logic [SP_W-1:0] wake_sp;
    logic            wake_en;
    logic [SP_W-1:0] sleep_sp;
    logic            sleep_en;
    logic [SP_W-1:0] run_sp;
    logic            run_en;
  } ctrl_t;
endpackage

// File: rtl/sptr_arb.sv
module sptr_arb
  import sptr_pkg::*;
(
  input  logic            idle,
  input  logic            sleep_pulse,
  input  logic            wake_pulse,
  input  ctrl_t           ctrl,
  input  logic [SP_W-1:0] prev_sp,
  output logic            fire,
  output src_e            src,
  output logic [SP_W-1:0] tgt
);
  logic wake_go, sleep_go, run_go;

  always_comb begin
    wake_go  = idle & wake_pulse & ctrl.wake_en;
    sleep_go = idle & sleep_pulse & ctrl.sleep_en & ~wake_go;
    run_go   = idle & ctrl.run_en & ~wake_go & ~sleep_go;
    fire     = wake_go | sleep_go | run_go;
    if (wake_go) begin
      src = SRC_WAKE;
      tgt = ctrl.wake_sel ? ctrl.wake_sp : prev_sp;
    end else if (sleep_go) begin
      src = SRC_SLEEP;
      tgt = ctrl.sleep_sp;
    end else begin
      src = SRC_RUN;
      tgt = ctrl.run_sp;
    end
  end
endmodule

// File: rtl/sptr_perm.sv
module sptr_perm
  import sptr_pkg::*;
#(
  parameter int              ADDR_W   = 3,
  parameter logic [NUM_SP-1:0] MASK_RST = '1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [NUM_SP-1:0]                 wdata,
  input  logic [1:0]                        mode,
  input  logic [SP_W-1:0]                   sp,
  output logic [NUM_MODES-1:0][NUM_SP-1:0]  mask_q,
  output logic                              ok
);
  for (genvar k = 0; k < NUM_MODES; k++) begin : g_mask
    logic            mask_en;
    logic [NUM_SP-1:0] mask_nxt;
    always_comb begin
      mask_en  = wr && (addr == ADDR_W'(IDX_MAP0 + k));
      mask_nxt = mask_en ? wdata : mask_q[k];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q[k] <= MASK_RST;
      else if (mask_en) mask_q[k] <= mask_nxt;
    end
  end

  assign ok = mask_q[mode][sp];
endmodule

// File: rtl/sptr_irq.sv
module sptr_irq
  import sptr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set,
  input  logic               en_wr,
  input  logic [NUM_SRC-1:0] en_wdata,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] flag_q,
  output logic               irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (en_wr) en_q <= en_wdata;
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_flag
    logic flag_en, flag_nxt;
    always_comb begin
      flag_en  = set[k] | clr[k];
      flag_nxt = set[k];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[k] <= 1'b0;
      else if (flag_en) flag_q[k] <= flag_nxt;
    end

    a_r11_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      set[k] |=> flag_q[k]);
  end

  assign irq = |(flag_q & en_q);
endmodule

// File: rtl/sp_request_ctrl.sv
module sp_request_ctrl
  import sptr_pkg::*;
#(
  parameter int          ADDR_W   = 3,
  parameter logic [15:0] MASK_RST = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [1:0]        cpu_mode,
  input  logic              sleep_start,
  input  logic              wakeup_start,
  output logic              sys_req,
  output logic [SP_W-1:0]   sys_sp,
  input  logic              sys_ack,
  output logic              irq
);
  localparam int CTRL_W = $bits(ctrl_t);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  ctrl_t           ctrl_q, ctrl_nxt;
  logic            busy_q, busy_nxt;
  src_e            src_q, src_nxt;
  logic [SP_W-1:0] cur_q, prev_q, tgt_q;
  logic [SP_W-1:0] cur_nxt, prev_nxt, tgt_nxt;
  logic            ctrl_wr, int_wr, ack_done, stat_en, tgt_en;

  logic            fire, perm_ok;
  src_e            arb_src;
  logic [SP_W-1:0] arb_tgt;
  logic [NUM_MODES-1:0][NUM_SP-1:0] mask_q;
  logic [NUM_SRC-1:0] irq_set, irq_clr, irq_en_q, irq_flag_q;

  sptr_arb u_arb (
    .idle        (~busy_q),
    .sleep_pulse (sleep_start),
    .wake_pulse  (wakeup_start),
    .ctrl        (ctrl_q),
    .prev_sp     (prev_q),
    .fire        (fire),
    .src         (arb_src),
    .tgt         (arb_tgt)
  );

  sptr_perm #(.ADDR_W(ADDR_W), .MASK_RST(MASK_RST)) u_perm (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata[NUM_SP-1:0]),
    .mode   (cpu_mode),
    .sp     (arb_tgt),
    .mask_q (mask_q),
    .ok     (perm_ok)
  );

  always_comb begin
    int_wr  = reg_wr && (reg_addr == ADDR_W'(IDX_INT));
    irq_clr = int_wr ? reg_wdata[INT_FLAG_LSB +: NUM_SRC] : '0;
    irq_set = '0;
    if (fire && !perm_ok) irq_set[arb_src] = 1'b1;
  end

  sptr_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .set      (irq_set),
    .en_wr    (int_wr),
    .en_wdata (reg_wdata[NUM_SRC-1:0]),
    .clr      (irq_clr),
    .en_q     (irq_en_q),
    .flag_q   (irq_flag_q),
    .irq      (irq)
  );

  // Next-state logic
  always_comb begin
    ctrl_wr  = reg_wr && (reg_addr == ADDR_W'(IDX_CTRL));
    ack_done = busy_q && sys_ack;
    ctrl_nxt = ctrl_wr ? ctrl_t'(reg_wdata[CTRL_W-1:0]) : ctrl_q;
    busy_nxt = busy_q;
    src_nxt  = src_q;
    cur_nxt  = cur_q;
    prev_nxt = prev_q;
    tgt_nxt  = tgt_q;
    stat_en  = 1'b0;
    tgt_en   = 1'b0;
    if (fire) begin
      tgt_en  = 1'b1;
      tgt_nxt = arb_tgt;
      unique case (arb_src)
        SRC_SLEEP: ctrl_nxt.sleep_en = 1'b0;
        SRC_WAKE:  ctrl_nxt.wake_en  = 1'b0;
        default:   if (!perm_ok) ctrl_nxt.run_en = 1'b0;
      endcase
      if (perm_ok) begin
        busy_nxt = 1'b1;
        src_nxt  = arb_src;
      end
    end
    if (ack_done) begin
      stat_en  = 1'b1;
      busy_nxt = 1'b0;
      cur_nxt  = tgt_q;
      prev_nxt = cur_q;
      if (src_q == SRC_RUN) ctrl_nxt.run_en = 1'b0;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ctrl_q <= '0;
      busy_q <= 1'b0;
      src_q  <= SRC_RUN;
      cur_q  <= '0;
      prev_q <= '0;
      tgt_q  <= '0;
    end else begin
      ctrl_q <= ctrl_nxt;
      busy_q <= busy_nxt;
      src_q  <= src_nxt;
      if (stat_en) begin
        cur_q  <= cur_nxt;
        prev_q <= prev_nxt;
      end
      if (tgt_en) tgt_q <= tgt_nxt;
    end
  end

  assign sys_req = busy_q;
  assign sys_sp  = tgt_q;

  // Read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(IDX_CTRL))
      reg_rdata[CTRL_W-1:0] = ctrl_q;
    else if (reg_addr == ADDR_W'(IDX_INT)) begin
      reg_rdata[NUM_SRC-1:0] = irq_en_q;
      reg_rdata[INT_FLAG_LSB +: NUM_SRC] = irq_flag_q;
    end else if (reg_addr == ADDR_W'(IDX_STAT))
      reg_rdata[3*SP_W-1:0] = {tgt_q, prev_q, cur_q};
    else begin
      for (int k = 0; k < NUM_MODES; k++)
        if (reg_addr == ADDR_W'(IDX_MAP0 + k)) reg_rdata[NUM_SP-1:0] = mask_q[k];
    end
  end

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sys_req && !sys_ack) |=> (sys_req && $stable(sys_sp)));

  a_r4_commit: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sys_req && sys_ack) |=> (!sys_req && cur_q == $past(sys_sp) && prev_q == $past(cur_q)));

  a_r6_only_allowed: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(sys_req) |-> $past(perm_ok));

  a_r3_run_pending: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sys_req && !sys_ack && src_q == SRC_RUN && !reg_wr) |=> ctrl_q.run_en);

  a_r7_sleep_disarm: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sleep_start && !wakeup_start && ctrl_q.sleep_en && !sys_req && !reg_wr) |=> !ctrl_q.sleep_en);
endmodule

// File: tb/tb_sp_request_ctrl.sv
module tb_sp_request_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [1:0]  cpu_mode;
  logic        sleep_start, wakeup_start, sys_req, sys_ack, irq;
  logic [3:0]  sys_sp;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int m_cur = 0, m_prev = 0;

  always #2 clk = ~clk;

  sp_request_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_mode(cpu_mode),
    .sleep_start(sleep_start), .wakeup_start(wakeup_start),
    .sys_req(sys_req), .sys_sp(sys_sp), .sys_ack(sys_ack), .irq(irq)
  );

  // {mode, mask, setpoint}; expected permission comes from mask bit
  localparam logic [21:0] VEC [6] = '{
    {2'd0, 16'hFFFF, 4'd5},
    {2'd1, 16'h0008, 4'd3},
    {2'd2, 16'h7FFF, 4'd15},
    {2'd3, 16'h8000, 4'd15},
    {2'd1, 16'h0008, 4'd4},
    {2'd2, 16'h0001, 4'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic pulse(input bit slp, input bit wak);
    @(negedge clk);
    sleep_start = slp; wakeup_start = wak;
    @(negedge clk);
    sleep_start = 1'b0; wakeup_start = 1'b0;
  endtask

  task automatic ack(input int exp_sp, input string req);
    logic [31:0] d;
    sys_ack = 1'b1;
    @(negedge clk);
    sys_ack = 1'b0;
    check(req, {31'd0, sys_req}, 32'd0);
    rd(3'd2, d);
    check(req, d[7:0], {4'(m_cur), 4'(exp_sp)});
    m_prev = m_cur; m_cur = exp_sp;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    cpu_mode = '0; sleep_start = 1'b0; wakeup_start = 1'b0; sys_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 3; a++) begin
      rd(3'(a), d); check("R1 reg zero", d, 32'd0);
    end
    for (int a = 3; a < 7; a++) begin
      rd(3'(a), d); check("R1 mask ones", d, 32'h0000_FFFF);
    end
    check("R1 outputs", {30'd0, sys_req, irq}, 32'd0);

    // R2 control readback, upper bits zero
    wr(3'd0, 32'hFFFF_FFFE);
    rd(3'd0, d); check("R2 ctrl readback", d, 32'h0000_FFFE);
    wr(3'd0, 32'h0);

    // Vector table: R3 R4 R6 R11
    wr(3'd1, 32'h4);
    for (int i = 0; i < 6; i++) begin
      logic [1:0] md; logic [15:0] mk; logic [3:0] sp; bit ok;
      {md, mk, sp} = VEC[i];
      ok = mk[sp];
      wr(3'(3 + md), {16'd0, mk});
      cpu_mode = md;
      wr(3'd0, {27'd0, sp, 1'b1});
      @(negedge clk);
      check("R6 permission", {31'd0, sys_req}, {31'd0, ok});
      if (ok) begin
        check("R3 sys_sp", {28'd0, sys_sp}, {28'd0, sp});
        rd(3'd0, d); check("R3 run bit pending", {31'd0, d[0]}, 32'd1);
        @(negedge clk);
        check("R5 hold", {27'd0, sys_req, sys_sp}, {27'd0, 1'b1, sp});
        ack(sp, "R4 commit");
        rd(3'd0, d); check("R4 run bit cleared", {31'd0, d[0]}, 32'd0);
      end else begin
        rd(3'd0, d); check("R6 run bit cleared", {31'd0, d[0]}, 32'd0);
        rd(3'd2, d); check("R12 status after refusal", d, {20'd0, sp, 4'(m_prev), 4'(m_cur)});
        rd(3'd1, d); check("R11 soft flag", d, 32'h0004_0004);
        check("R11 irq", {31'd0, irq}, 32'd1);
        wr(3'd1, 32'h0004_0004);
        check("R11 w1c", {31'd0, irq}, 32'd0);
      end
    end

    // Directed tests; all masks open, mode RUN
    for (int m = 0; m < 4; m++) wr(3'(3 + m), 32'hFFFF);
    cpu_mode = 2'd0;

    // R7 sleep request
    wr(3'd0, 32'h1E0);
    pulse(1'b1, 1'b0);
    check("R7 sleep request", {27'd0, sys_req, sys_sp}, {27'd0, 1'b1, 4'd7});
    rd(3'd0, d); check("R7 sleep en cleared", d, 32'h1C0);
    ack(7, "R7 commit");

    // R8 wakeup, select 0 -> previous setpoint
    wr(3'd0, 32'h6400);
    pulse(1'b0, 1'b1);
    check("R8 wakeup to previous", {27'd0, sys_req, sys_sp}, {27'd0, 1'b1, 4'(m_prev)});
    rd(3'd0, d); check("R8 wake en cleared", d, 32'h6000);
    ack(m_prev, "R8 commit prev");

    // R8 wakeup, select 1 -> field
    wr(3'd0, 32'hE400);
    pulse(1'b0, 1'b1);
    check("R8 wakeup to field", {27'd0, sys_req, sys_sp}, {27'd0, 1'b1, 4'd12});
    ack(12, "R8 commit field");

    // R7 pulse without enable
    wr(3'd0, 32'h1C0);
    pulse(1'b1, 1'b0);
    check("R7 no enable", {31'd0, sys_req}, 32'd0);

    // R11 refused sleep, write 0 keeps flag
    wr(3'd3, 32'hFF7F);
    wr(3'd1, 32'h7);
    wr(3'd0, 32'h1E0);
    pulse(1'b1, 1'b0);
    check("R6 refused sleep", {31'd0, sys_req}, 32'd0);
    rd(3'd2, d); check("R6 current kept", d, {20'd0, 4'd7, 4'(m_prev), 4'(m_cur)});
    rd(3'd1, d); check("R11 sleep flag", d, 32'h0001_0007);
    wr(3'd1, 32'h7);
    rd(3'd1, d); check("R11 zero keeps flag", d, 32'h0001_0007);
    check("R11 irq sleep", {31'd0, irq}, 32'd1);
    wr(3'd1, 32'h0001_0007);
    check("R11 cleared", {31'd0, irq}, 32'd0);
    wr(3'd3, 32'hFFFF);

    // R9 sleep and run in the same cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h265;
    @(negedge clk);
    reg_wr = 1'b0; sleep_start = 1'b1;
    @(negedge clk);
    sleep_start = 1'b0;
    check("R9 sleep wins", {27'd0, sys_req, sys_sp}, {27'd0, 1'b1, 4'd9});
    rd(3'd0, d); check("R9 run still pending", d, 32'h245);
    ack(9, "R9 commit sleep");
    @(negedge clk);
    check("R9 run after", {27'd0, sys_req, sys_sp}, {27'd0, 1'b1, 4'd2});

    // R10 pulse while busy
    wr(3'd0, 32'h265);
    pulse(1'b1, 1'b0);
    check("R10 busy ignores pulse", {27'd0, sys_req, sys_sp}, {27'd0, 1'b1, 4'd2});
    rd(3'd0, d); check("R10 enable kept", d, 32'h265);
    ack(2, "R10 commit run");
    rd(3'd0, d); check("R4 run cleared sleep armed", d, 32'h264);
    wr(3'd0, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule